// File: doc/BRIEF.md
# Command-Driven Serial Shift Engine

This block sits between a byte-wide command stream and a four-wire synchronous serial port. Each command opens with an opcode byte, and the bits of that byte choose the transfer options independently of each other. Bit 0 picks the edge that launches output. Bit 1 picks bit or byte counting. Bit 2 picks the edge that samples input. Bit 3 picks the shift order. Bit 4 enables driving data. Bit 5 enables capturing data. Bit 6 routes the payload to the mode-select pin. An opcode with bit 7 set is a special command. This engine does not support special commands, so it flags the byte and discards it.

A length field follows the opcode. Payload bytes follow the length only when driving is enabled. The engine then toggles the serial clock at a rate set by a divider input. Every byte captured from the data-in pin goes out on a separate response byte stream.

Both byte streams use valid/ready handshakes. A byte moves on a rising system clock edge where valid and ready are both high. The command side holds ready low while bits are shifting. When the response holder is still full as a captured byte completes, the engine stops the serial clock (held low) until the consumer takes the held byte.

Top module: `shift_cmd_engine`

## Requirements
- R1: When opcode bit 1 is 0 (byte count), the engine takes the opcode, then a length low byte, then a length high byte. The 16-bit value is the byte count minus one. When bit 4 is set, one payload byte is taken before each transferred byte.
- R2: When opcode bit 1 is 1 (bit count), one length byte follows the opcode. Only its low 3 bits are used, and they give the bit count minus one, so 1 to 8 bits move. When bit 4 is set, exactly one payload byte follows.
- R3: When opcode bit 0 is 0, each output bit is driven at a rising serial clock edge. When bit 0 is 1, the first bit is driven before the first rising edge and each later bit at a falling edge.
- R4: When opcode bit 2 is 0, data-in is sampled at rising serial clock edges. When bit 2 is 1, it is sampled at falling edges.
- R5: When opcode bit 3 is 0, payload bits leave starting from bit 7, and captured bits enter at bit 0 and shift upward, so an n-bit capture fills bits n-1..0. When bit 3 is 1, payload bits leave starting from bit 0, and captured bits enter at bit 7 and shift downward, so an n-bit capture fills bits 7..8-n. Unfilled bits read 0.
- R6: Opcode bit 4 enables driving. Opcode bit 5 enables capture, and in that case every completed byte, or the one packed bit-mode byte, is offered once on the response stream in capture order. Both bits may be set for full duplex.
- R7: When opcode bits 6 and 4 are set, payload bits are driven on the mode-select pin at the same edges, and the data-out pin keeps its value.
- R8: An opcode byte with bit 7 set causes a single-cycle pulse on `bad_op_o`. No serial clock edge follows, and the next byte is again taken as an opcode.
- R9: The serial clock is low whenever no transfer is running. Each high and low phase lasts `div_i`+1 system clock cycles.
- R10: `cmd_ready` is high while the engine waits for an opcode, a length or a payload byte. It is low while bits shift and while a captured byte waits to be delivered.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds its value. A newly completed byte is held back and the serial clock stays low until the slot frees. No byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Half-period of the serial clock, minus one, in system cycles |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Engine accepts a command byte |
| cmd_data | input | 8 | Command byte (opcode, length or payload) |
| rsp_valid | output | 1 | Captured byte valid |
| rsp_ready | input | 1 | Consumer accepts the captured byte |
| rsp_data | output | 8 | Captured byte |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| sms_o | output | 1 | Mode-select output |
| bad_op_o | output | 1 | One-cycle pulse for a dropped special opcode |

## Verification
Two events can fall in one cycle: the consumer popping the response holder, and the engine loading a newly captured byte into it. The bench provokes this by holding `rsp_ready` low through a two-byte capture, so the second byte is blocked behind the first. It then raises `rsp_ready`, and the pop and the reload happen on the same edge. The run is judged from the stream: exactly two bytes arrive, in capture order, with the expected values. During the stall the held byte must stay stable, the serial clock must stay low and the command side must stay closed.

// File: rtl/sce_pkg.sv
package sce_pkg;
  // Opcode bit positions are behavioural: bit 7 down to bit 0.
  typedef struct packed {
    logic special;
    logic msel;
    logic din;
    logic dout;
    logic lsb;
    logic sneg;
    logic bits;
    logic lneg;
  } sce_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LLO,
    ST_LHI,
    ST_PAY,
    ST_SHIFT,
    ST_PUSH
  } sce_state_t;
endpackage

// File: rtl/sce_opdec.sv
module sce_opdec
  import sce_pkg::*;
#(
  parameter int BW = 8,
  localparam int IW = $clog2(BW)
) (
  input  logic [BW-1:0] op_byte,
  input  logic [BW-1:0] len_byte,
  input  logic [BW-1:0] pay_byte,
  output sce_op_t       op,
  output logic [IW-1:0] last_idx,
  output logic          first_bit
);
  assign op        = sce_op_t'(op_byte);
  assign last_idx  = op.bits ? len_byte[IW-1:0] : IW'(BW - 1);
  assign first_bit = op.lsb ? pay_byte[0] : pay_byte[BW-1];
endmodule

// File: rtl/sce_tick.sv
module sce_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sce_lane.sv
module sce_lane #(
  parameter int BW = 8,
  localparam int IW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_tx,
  input  logic [BW-1:0] tx_in,
  input  logic          lsb,
  input  logic [IW-1:0] idx,
  input  logic          cap,
  input  logic          clr,
  input  logic          sdi,
  output logic          bit_out,
  output logic [BW-1:0] rx_q
);
  logic [BW-1:0] tx_q;

  assign bit_out = lsb ? tx_q[idx] : tx_q[IW'(BW - 1) - idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_tx) tx_q <= tx_in;
      if (clr)      rx_q <= '0;
      else if (cap) rx_q <= lsb ? {sdi, rx_q[BW-1:1]} : {rx_q[BW-2:0], sdi};
    end
  end
endmodule

// File: rtl/shift_cmd_engine.sv
module shift_cmd_engine
  import sce_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             sclk_o,
  output logic             sdo_o,
  input  logic             sdi_i,
  output logic             sms_o,
  output logic             bad_op_o
);
  localparam int BW    = 8;
  localparam int IW    = $clog2(BW);
  localparam int LEN_W = 2 * BW;

  sce_state_t       state_q;
  logic [BW-1:0]    op_raw_q;
  sce_op_t          op;
  logic [IW-1:0]    last_dec, last_q, idx_q, lidx;
  logic             ph_q, tick, first_bit, bit_out;
  logic [LEN_W-1:0] remain_q;
  logic [BW-1:0]    rx_q;
  logic             cmd_hs, load_tx, cap, slot_free, byte_end;
  logic             unit_done, start_shift, drive_en, drive_val;

  sce_opdec #(.BW(BW)) u_dec (
    .op_byte(op_raw_q), .len_byte(cmd_data), .pay_byte(cmd_data),
    .op(op), .last_idx(last_dec), .first_bit(first_bit)
  );

  sce_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_SHIFT), .div_i(div_i), .tick(tick)
  );

  sce_lane #(.BW(BW)) u_lane (
    .clk(clk), .rst_n(rst_n), .load_tx(load_tx), .tx_in(cmd_data), .lsb(op.lsb),
    .idx(lidx), .cap(cap), .clr(start_shift), .sdi(sdi_i),
    .bit_out(bit_out), .rx_q(rx_q)
  );

  assign cmd_ready = (state_q == ST_IDLE) || (state_q == ST_LLO) ||
                     (state_q == ST_LHI)  || (state_q == ST_PAY);
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign load_tx   = (state_q == ST_PAY) && cmd_hs;
  assign lidx      = ph_q ? IW'(idx_q + 1'b1) : idx_q;
  assign slot_free = !rsp_valid || rsp_ready;

  always_comb begin
    byte_end  = (state_q == ST_SHIFT) && tick && ph_q && (idx_q == last_q);
    cap       = (state_q == ST_SHIFT) && tick && op.din && (ph_q == op.sneg);
    unit_done = (byte_end && !op.din) || ((state_q == ST_PUSH) && slot_free);
    start_shift = load_tx ||
                  ((state_q == ST_LLO) && cmd_hs && op.bits && !op.dout) ||
                  ((state_q == ST_LHI) && cmd_hs && !op.dout) ||
                  (unit_done && (remain_q != '0) && !op.dout);
    drive_en  = op.dout && ((load_tx && op.lneg) ||
                ((state_q == ST_SHIFT) && tick &&
                 (ph_q ? (op.lneg && (idx_q != last_q)) : !op.lneg)));
    drive_val = load_tx ? first_bit : bit_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_raw_q  <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      ph_q      <= 1'b0;
      remain_q  <= '0;
      sclk_o    <= 1'b0;
      bad_op_o  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      bad_op_o <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (cmd_hs) begin
          if (cmd_data[BW-1]) bad_op_o <= 1'b1;
          else begin
            op_raw_q <= cmd_data;
            state_q  <= ST_LLO;
          end
        end
        ST_LLO: if (cmd_hs) begin
          last_q   <= last_dec;
          remain_q <= op.bits ? '0 : LEN_W'(cmd_data);
          if (op.bits) state_q <= op.dout ? ST_PAY : ST_SHIFT;
          else         state_q <= ST_LHI;
        end
        ST_LHI: if (cmd_hs) begin
          remain_q[LEN_W-1:BW] <= cmd_data;
          state_q <= op.dout ? ST_PAY : ST_SHIFT;
        end
        ST_PAY: if (cmd_hs) state_q <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          ph_q   <= !ph_q;
          sclk_o <= !ph_q;
          if (ph_q) begin
            if (idx_q != last_q) idx_q <= idx_q + 1'b1;
            else if (op.din)     state_q <= ST_PUSH;
          end
        end
        ST_PUSH: if (slot_free) begin
          rsp_data  <= rx_q;
          rsp_valid <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (unit_done) begin
        if (remain_q != '0) begin
          remain_q <= remain_q - 1'b1;
          state_q  <= op.dout ? ST_PAY : ST_SHIFT;
        end else begin
          state_q <= ST_IDLE;
        end
      end
      if (start_shift) begin
        idx_q <= '0;
        ph_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdo_o <= 1'b0;
      sms_o <= 1'b0;
    end else if (drive_en) begin
      if (op.msel) sms_o <= drive_val;
      else         sdo_o <= drive_val;
    end
  end

  // R9: the serial clock never stays high once the engine is idle
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sclk_o);

  // R10: no command byte is taken while the clock is high mid-transfer
  assert_ready_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cmd_ready);

  // R11: a held response keeps its value until consumed
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8: each pulse follows an accepted special byte
  assert_bad_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op_o |-> $past(cmd_valid && cmd_ready && cmd_data[BW-1]));

  // R7: mode-select shifting leaves the data pin alone
  assert_msel_sdo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SHIFT) && op.msel) |=> $stable(sdo_o));
endmodule

// File: tb/shift_cmd_engine_tb_top.sv
module shift_cmd_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = 8'd1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       sclk_o, sdo_o, sms_o, bad_op_o;
  logic       sdi_i = 1'b0;

  int tests = 0;
  int fails = 0;

  shift_cmd_engine #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_i(div_i),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .sms_o(sms_o), .bad_op_o(bad_op_o)
  );

  always #10 clk = !clk;

  // peripheral model and monitors
  logic        armed = 1'b0;
  logic [7:0]  cur_op = 8'h00;
  logic [15:0] sdi_seq = 16'h0;
  logic [15:0] mon_seq = 16'h0;
  int          mon_n = 0, sdi_k = 0, rsp_n = 0, bad_n = 0, rises = 0;
  int          hi_run = 0, last_hi = 0;
  logic [7:0]  rsp_got [4];

  always @(posedge sclk_o) if (armed) begin
    rises++;
    if (cur_op[0] && mon_n < 16) begin
      mon_seq[mon_n] = cur_op[6] ? sms_o : sdo_o;
      mon_n++;
    end
    if (cur_op[2] && sdi_k < 16) begin
      sdi_i = sdi_seq[sdi_k];
      sdi_k++;
    end
  end

  always @(negedge sclk_o) if (armed) begin
    if (!cur_op[0] && mon_n < 16) begin
      mon_seq[mon_n] = cur_op[6] ? sms_o : sdo_o;
      mon_n++;
    end
    if (!cur_op[2] && sdi_k < 15) begin
      sdi_k++;
      sdi_i = sdi_seq[sdi_k];
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready && rsp_n < 4) begin
      rsp_got[rsp_n] = rsp_data;
      rsp_n++;
    end
    if (rst_n && bad_op_o) bad_n++;
    if (sclk_o) hi_run++;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op, input logic [15:0] len,
                       input logic [7:0] p0, input logic [7:0] p1, input logic [15:0] sq);
    cur_op  = op;
    sdi_seq = sq;
    mon_seq = '0;
    mon_n   = 0;
    rsp_n   = 0;
    sdi_k   = 0;
    sdi_i   = op[2] ? 1'b0 : sq[0];
    send(op);
    send(len[7:0]);
    if (!op[1]) send(len[15:8]);
    if (op[4]) begin
      send(p0);
      if (!op[1] && len != 16'h0) send(p1);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(cmd_ready && !sclk_o)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // op, len, payload, sdi wire order, expected wire order, bit count, expected response
  localparam logic [55:0] VEC [12] = '{
    56'h10_00_1D_00_B8_08_00,
    56'h19_00_1D_00_1D_08_00,
    56'h20_00_00_0B_00_08_D0,
    56'h2C_00_00_0B_00_08_0B,
    56'h31_00_1D_0B_B8_08_D0,
    56'h12_02_C6_00_03_03_00,
    56'h1A_04_C6_00_06_05_00,
    56'h22_03_00_0B_00_04_0D,
    56'h2A_03_00_0B_00_04_B0,
    56'h26_00_00_0B_00_01_01,
    56'h5B_06_45_00_45_07_00,
    56'h12_F9_C6_00_03_02_00
  };

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=idle");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", 32'(cmd_ready), 32'd1);
    chk("R9 sclk idle after reset", 32'(sclk_o), 32'd0);
    chk("R6 no response after reset", 32'(rsp_valid), 32'd0);
    chk("R8 no flag after reset", 32'(bad_op_o), 32'd0);
    armed = 1'b1;

    for (int i = 0; i < 12; i++) begin
      logic [55:0] v;
      logic [7:0]  m;
      logic        sdo_before;
      v = VEC[i];
      m = 8'hFF >> (8 - int'(v[15:8]));
      sdo_before = sdo_o;
      issue(v[55:48], {8'h00, v[47:40]}, v[39:32], 8'h00, {8'h00, v[31:24]});
      wait_idle();
      if (v[52]) begin
        chk(v[49] ? "R2 bit count" : "R1 byte count", 32'(mon_n), 32'(v[15:8]));
        chk(v[54] ? "R7 mode-select order" : "R3/R5 output order",
            32'(mon_seq[7:0] & m), 32'(v[23:16]));
      end
      if (v[53]) begin
        chk("R6 one response", 32'(rsp_n), 32'd1);
        chk("R4/R5 captured byte", 32'(rsp_got[0]), 32'(v[7:0]));
      end
      if (v[54]) chk("R7 data pin held", 32'(sdo_o), 32'(sdo_before));
      chk("R8 no flag on transfer", 32'(bad_n), 32'd0);
    end

    // R1 multi-byte full duplex with a two-byte length
    issue(8'h31, 16'h0001, 8'h1D, 8'hC6, 16'hF00B);
    wait_idle();
    chk("R1 two bytes clocked", 32'(mon_n), 32'd16);
    chk("R3 two-byte output order", 32'(mon_seq), 32'h63B8);
    chk("R6 two responses", 32'(rsp_n), 32'd2);
    chk("R6 first response", 32'(rsp_got[0]), 32'hD0);
    chk("R6 second response", 32'(rsp_got[1]), 32'h0F);

    // R11 back-pressure with simultaneous pop and reload
    rsp_ready = 1'b0;
    issue(8'h20, 16'h0001, 8'h00, 8'h00, 16'hF00B);
    repeat (150) @(negedge clk);
    chk("R11 held valid", 32'(rsp_valid), 32'd1);
    chk("R11 held data", 32'(rsp_data), 32'hD0);
    chk("R11 clock stalled", 32'(sclk_o), 32'd0);
    chk("R10 ready low in stall", 32'(cmd_ready), 32'd0);
    repeat (20) @(negedge clk);
    chk("R11 data stable", 32'(rsp_data), 32'hD0);
    rsp_ready = 1'b1;
    wait_idle();
    chk("R11 both delivered", 32'(rsp_n), 32'd2);
    chk("R11 order first", 32'(rsp_got[0]), 32'hD0);
    chk("R11 order second", 32'(rsp_got[1]), 32'h0F);

    // R8 special opcodes dropped
    bad_n = 0;
    rises = 0;
    send(8'h86);
    send(8'h9E);
    repeat (10) @(negedge clk);
    chk("R8 two flags", 32'(bad_n), 32'd2);
    chk("R8 no clocking", 32'(rises), 32'd0);
    chk("R8 ready kept", 32'(cmd_ready), 32'd1);
    issue(8'h10, 16'h0000, 8'h1D, 8'h00, 16'h0000);
    wait_idle();
    chk("R8 framing intact", 32'(mon_seq[7:0]), 32'hB8);

    // R9 divider
    div_i = 8'd3;
    issue(8'h10, 16'h0000, 8'h1D, 8'h00, 16'h0000);
    wait_idle();
    chk("R9 high phase div 3", 32'(last_hi), 32'd4);
    div_i = 8'd0;
    issue(8'h10, 16'h0000, 8'h1D, 8'h00, 16'h0000);
    wait_idle();
    chk("R9 high phase div 0", 32'(last_hi), 32'd1);
    chk("R3 output at fastest rate", 32'(mon_seq[7:0]), 32'hB8);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule